// File: doc/BRIEF.md
# 32-Source Priority Interrupt Controller

This block gathers thirty-two interrupt request lines into sticky pending bits and tells the processor which one to service next. A request counts when its line goes from low to high; the pending bit stays set until the processor acknowledges that source by its index. This holds even if the line has dropped again in the meantime.

Selection happens in two layers. The first layer is four priority encoders of eight inputs each. The second layer is a final pick across the groups. Priority is fixed, and a lower source index always wins. Software controls eligibility per half. The sources fall into two banks of sixteen. Each bank has a mask word with one bit per source, and a switch that shuts off the whole bank. Masking only affects reporting. A masked source still records its edge, and it is reported once it is unmasked. The winner appears in a 6-bit status word.

Top module: `irq_prio_ctl`

## Requirements
- R1: A low-to-high transition on `irq_req_i[k]`, sampled at a clock edge, sets `pending_o[k]` after that edge. A line held high does not set the bit again once it has been acknowledged.
- R2: Among the sources that are pending and eligible, the one with the smallest index is reported.
- R3: `status_o[5]` is a valid flag and `status_o[4:0]` is the index of the reported source. `status_o` is all zeros when no source is both pending and eligible.
- R4: Writing 1 to mask bit j of bank b stops source b*16+j from being reported. Its pending bit is still set by a new edge. It is reported once the mask bit is cleared again.
- R5: Setting a bank's shut-off flag stops all sixteen sources of that bank from being reported, whatever the bank's mask bits are.
- R6: An acknowledge (`ack_valid_i` high with index `ack_idx_i`) clears that pending bit after the edge. Acknowledging a source that is not pending changes no pending bit.
- R7: If an acknowledge and a new rising edge hit the same source in the same cycle, the pending bit remains set.
- R8: After reset, no bit is pending, all mask bits and both shut-off flags are clear, and `status_o` is zero.
- R9: A pending bit stays set while no acknowledge names it, even after its request line has fallen.
- R10: A mask write (`mask_we_i` high) loads `mask_bits_i` and `bank_off_i` into the bank chosen by `mask_bank_i` (0 for sources 0-15, 1 for sources 16-31). It takes effect from the next cycle and leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 32 | Request lines, edge-detected |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 5 | Index of the acknowledged source |
| mask_we_i | input | 1 | Write strobe for a bank's mask and shut-off flag |
| mask_bank_i | input | 1 | Bank chosen by the write |
| mask_bits_i | input | 16 | Per-source mask value, 1 blocks reporting |
| bank_off_i | input | 1 | Shut-off flag value, 1 blocks the whole bank |
| pending_o | output | 32 | Pending bits |
| status_o | output | 6 | {valid, index} of the highest-priority eligible source |

## Verification
The first sweep raises each source on its own. This separates index encoding errors from priority errors. The second sweep raises every pair of sources and acknowledges them in turn. It shows whether the winner is the smaller index both inside a group and across group and bank boundaries, and whether the loser is still reported afterwards.

A third sweep grows a masked prefix one source at a time across both banks, with all sources pending. It tells per-bit masking apart from the bank shut-off, which is tried on each bank separately. Directed sequences cover a level held across an acknowledge, an acknowledge that coincides with a fresh edge, and acknowledges of sources that are not pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned IRQ_SRC_N  = 32;
    localparam int unsigned IRQ_GRP_W  = 8;
    localparam int unsigned IRQ_BANK_W = 16;

    // widest in-group selector the group encoder can report
    localparam int unsigned GSEL_W = 8;

    typedef struct packed {
        logic              hit;
        logic [GSEL_W-1:0] sel;
    } grp_pick_t;

    // number of bits needed to name one of n items, never below one
    function automatic int unsigned sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned SRC_N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] req_i,
    input  logic [SRC_N-1:0] ack_vec_i,
    output logic [SRC_N-1:0] pend_o
);

    logic [SRC_N-1:0] req_q;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[i]  <= 1'b0;
                pend_o[i] <= 1'b0;
            end else begin
                req_q[i]  <= req_i[i];
                // new edge wins over a same-cycle acknowledge
                pend_o[i] <= (pend_o[i] & ~ack_vec_i[i]) | (req_i[i] & ~req_q[i]);
            end
        end
    end

endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs #(
    parameter int unsigned BANK_W = 16,
    parameter int unsigned BANK_N = 2,
    parameter int unsigned BSEL_W = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [BSEL_W-1:0]        bank_i,
    input  logic [BANK_W-1:0]        bits_i,
    input  logic                     off_i,
    output logic [BANK_W*BANK_N-1:0] en_o
);

    for (genvar b = 0; b < BANK_N; b++) begin : g_bank
        logic [BANK_W-1:0] mask_q;
        logic              off_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
                off_q  <= 1'b0;
            end else if (we_i && (bank_i == BSEL_W'(b))) begin
                mask_q <= bits_i;
                off_q  <= off_i;
            end
        end

        assign en_o[b*BANK_W +: BANK_W] = off_q ? '0 : ~mask_q;
    end

endmodule

// File: rtl/irqc_group_pick.sv
module irqc_group_pick
    import irqc_pkg::*;
#(
    parameter int unsigned GRP_W = 8
) (
    input  logic [GRP_W-1:0] vec_i,
    output grp_pick_t        pick_o
);

    always_comb begin
        pick_o = '0;
        // scan downward so the lowest set bit is written last
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                pick_o.hit = 1'b1;
                pick_o.sel = GSEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_N  = IRQ_SRC_N,
    parameter int unsigned GRP_W  = IRQ_GRP_W,
    parameter int unsigned BANK_W = IRQ_BANK_W,
    localparam int unsigned IDX_W  = sel_bits(SRC_N),
    localparam int unsigned BANK_N = SRC_N / BANK_W,
    localparam int unsigned BSEL_W = sel_bits(BANK_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  irq_req_i,
    input  logic              ack_valid_i,
    input  logic [IDX_W-1:0]  ack_idx_i,
    input  logic              mask_we_i,
    input  logic [BSEL_W-1:0] mask_bank_i,
    input  logic [BANK_W-1:0] mask_bits_i,
    input  logic              bank_off_i,
    output logic [SRC_N-1:0]  pending_o,
    output logic [IDX_W:0]    status_o
);

    localparam int unsigned GRP_N = SRC_N / GRP_W;

    logic [SRC_N-1:0] ack_vec;
    logic [SRC_N-1:0] src_en;
    logic [SRC_N-1:0] elig;
    grp_pick_t        picks [GRP_N];
    logic             win_hit;
    logic [IDX_W-1:0] win_idx;

    always_comb begin
        ack_vec = '0;
        if (ack_valid_i) begin
            ack_vec[ack_idx_i] = 1'b1;
        end
    end

    irqc_capture #(
        .SRC_N (SRC_N)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .req_i     (irq_req_i),
        .ack_vec_i (ack_vec),
        .pend_o    (pending_o)
    );

    irqc_mask_regs #(
        .BANK_W (BANK_W),
        .BANK_N (BANK_N),
        .BSEL_W (BSEL_W)
    ) u_mask (
        .clk    (clk),
        .rst    (rst),
        .we_i   (mask_we_i),
        .bank_i (mask_bank_i),
        .bits_i (mask_bits_i),
        .off_i  (bank_off_i),
        .en_o   (src_en)
    );

    assign elig = pending_o & src_en;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        irqc_group_pick #(
            .GRP_W (GRP_W)
        ) u_pick (
            .vec_i  (elig[g*GRP_W +: GRP_W]),
            .pick_o (picks[g])
        );
    end

    // second layer: lowest group with a hit wins
    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int g = GRP_N - 1; g >= 0; g--) begin
            if (picks[g].hit) begin
                win_hit = 1'b1;
                win_idx = IDX_W'(g * GRP_W) + IDX_W'(picks[g].sel);
            end
        end
    end

    assign status_o = win_hit ? {1'b1, win_idx} : '0;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned SRC_N = 32,
    localparam int unsigned IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [SRC_N-1:0] req_i,
    input logic             ack_valid_i,
    input logic [IDX_W-1:0] ack_idx_i,
    input logic [SRC_N-1:0] pend_i,
    input logic [SRC_N-1:0] en_i,
    input logic [IDX_W:0]   status_i
);

    logic             st_valid;
    logic [IDX_W-1:0] st_idx;
    logic [SRC_N-1:0] below;
    logic [SRC_N-1:0] ack_sel;
    logic [SRC_N-1:0] keep;
    logic [SRC_N-1:0] req_prev;
    logic [SRC_N-1:0] fresh;

    assign st_valid = status_i[IDX_W];
    assign st_idx   = status_i[IDX_W-1:0];
    assign below    = (SRC_N'(1) << st_idx) - SRC_N'(1);
    assign ack_sel  = ack_valid_i ? (SRC_N'(1) << ack_idx_i) : '0;
    assign keep     = pend_i & ~ack_sel;
    assign fresh    = req_i & ~req_prev;

    always_ff @(posedge clk) begin
        if (rst) req_prev <= '0;
        else     req_prev <= req_i;
    end

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !st_valid |-> (status_i == '0));

    p_report_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (pend_i[st_idx] && en_i[st_idx]));

    p_none_eligible_r4: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_i) == '0) |-> !st_valid);

    p_lowest_wins_r2: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> ((pend_i & en_i & below) == '0));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_i && !req_i[ack_idx_i]) |=> !pend_i[$past(ack_idx_i)]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_i & $past(keep)) == $past(keep)));

    p_edge_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (fresh != '0) |=> ((pend_i & $past(fresh)) == $past(fresh)));

    // R7: acknowledge colliding with a fresh edge keeps the bit
    p_ack_edge_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_i && fresh[ack_idx_i]) |=> pend_i[$past(ack_idx_i)]);

endmodule

bind irq_prio_ctl irqc_checker #(
    .SRC_N (SRC_N)
) u_irqc_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (irq_req_i),
    .ack_valid_i (ack_valid_i),
    .ack_idx_i   (ack_idx_i),
    .pend_i      (pending_o),
    .en_i        (src_en),
    .status_i    (status_o)
);

// File: tb/irq_prio_ctl_bench.sv
module irq_prio_ctl_bench;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N  = 32;
    localparam int unsigned BW = 16;
    localparam int unsigned IW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req;
    logic          ack_v;
    logic [IW-1:0] ack_idx;
    logic          mwe;
    logic          mbank;
    logic [BW-1:0] mbits;
    logic          moff;
    logic [N-1:0]  pend;
    logic [IW:0]   status;

    // bench-side model
    logic [N-1:0]  m_pend, m_prev;
    logic [BW-1:0] m_mask0, m_mask1;
    logic          m_off0, m_off1;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    irq_prio_ctl u_irq_prio_ctl (
        .clk         (clk),
        .rst         (rst),
        .irq_req_i   (req),
        .ack_valid_i (ack_v),
        .ack_idx_i   (ack_idx),
        .mask_we_i   (mwe),
        .mask_bank_i (mbank),
        .mask_bits_i (mbits),
        .bank_off_i  (moff),
        .pending_o   (pend),
        .status_o    (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [IW:0] exp_status();
        logic [N-1:0] en;
        en[BW-1:0]  = m_off0 ? '0 : ~m_mask0;
        en[N-1:BW]  = m_off1 ? '0 : ~m_mask1;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && en[i]) return {1'b1, IW'(i)};
        end
        return '0;
    endfunction

    task automatic check(input string tag);
        logic [IW:0] e;
        e = exp_status();
        n_run++;
        if (status !== e) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, e);
        end
        n_run++;
        if (pend !== m_pend) begin
            n_fail++;
            $display("FAIL %s pending actual=%h expected=%h", tag, pend, m_pend);
        end
    endtask

    // one clock: model follows the inputs seen at the edge, then check at negedge
    task automatic cyc(input string tag);
        logic [N-1:0] av;
        @(posedge clk);
        av = ack_v ? (N'(1) << ack_idx) : '0;
        m_pend = (m_pend & ~av) | (req & ~m_prev);
        m_prev = req;
        if (mwe) begin
            if (mbank) begin m_mask1 = mbits; m_off1 = moff; end
            else       begin m_mask0 = mbits; m_off0 = moff; end
        end
        @(negedge clk);
        ack_v = 1'b0;
        mwe   = 1'b0;
        check(tag);
    endtask

    task automatic ack(input int unsigned k, input string tag);
        ack_v   = 1'b1;
        ack_idx = IW'(k);
        cyc(tag);
    endtask

    task automatic wr_mask(input logic b, input logic [BW-1:0] bits, input logic off,
                           input string tag);
        mwe   = 1'b1;
        mbank = b;
        mbits = bits;
        moff  = off;
        cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; ack_v = 1'b0; ack_idx = '0;
        mwe = 1'b0; mbank = 1'b0; mbits = '0; moff = 1'b0;
        m_pend = '0; m_prev = '0; m_mask0 = '0; m_mask1 = '0; m_off0 = 1'b0; m_off1 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset");

        // single-source sweep
        for (int i = 0; i < N; i++) begin
            req[i] = 1'b1; cyc("R1 edge latch");
            req[i] = 1'b0; cyc("R9 held after drop");
            ack(i, "R6 ack clears");
            check("R3 zero when idle");
        end

        // pair sweep: lower index wins, loser follows
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                req[i] = 1'b1; req[j] = 1'b1; cyc("R2 pair priority");
                req = '0;
                ack(i, "R2 loser reported");
                ack(j, "R6 pair cleared");
            end
        end

        // level held across acknowledge does not re-latch
        req[5] = 1'b1; cyc("R1 level start");
        ack(5, "R1 ack under level");
        cyc("R1 no relatch");
        req[5] = 1'b0; cyc("R1 level drop");

        // acknowledge coinciding with a fresh edge
        req[9] = 1'b1; cyc("R7 first edge");
        req[9] = 1'b0; cyc("R7 drop");
        req[9] = 1'b1; ack(9, "R7 ack with edge");
        req[9] = 1'b0; cyc("R7 still pending");
        ack(9, "R6 final clear");

        // masked source still latches, then reports when unmasked
        wr_mask(1'b0, 16'h0008, 1'b0, "R10 mask src3");
        req[3] = 1'b1; cyc("R4 masked latch");
        req[3] = 1'b0; cyc("R4 masked silent");
        wr_mask(1'b0, 16'h0000, 1'b0, "R4 unmask reports");
        ack(3, "R6 clear src3");

        // all pending, then growing masked prefix across both banks
        req = '1; cyc("R1 all edges");
        req = '0; cyc("R9 all held");
        for (int k = 0; k < N; k++) begin
            logic [BW-1:0] b0, b1;
            b0 = (k >= 15) ? '1 : BW'((32'd1 << (k + 1)) - 1);
            b1 = (k < 16) ? '0 : ((k >= 31) ? '1 : BW'((32'd1 << (k - 15)) - 1));
            wr_mask(1'b0, b0, 1'b0, "R4 prefix bank0");
            wr_mask(1'b1, b1, 1'b0, "R4 prefix bank1");
        end

        // bank shut-off
        wr_mask(1'b0, '0, 1'b0, "R10 clear bank0");
        wr_mask(1'b1, '0, 1'b0, "R10 clear bank1");
        wr_mask(1'b0, '0, 1'b1, "R5 bank0 off");
        wr_mask(1'b1, '0, 1'b1, "R5 both off");
        wr_mask(1'b0, '0, 1'b0, "R5 bank0 on");
        wr_mask(1'b1, 16'hFFFE, 1'b0, "R10 bank1 write keeps bank0");
        wr_mask(1'b0, 16'hFFFF, 1'b0, "R10 bank1 src16 visible");
        wr_mask(1'b0, 16'h0000, 1'b1, "R5 off overrides clear mask");
        wr_mask(1'b0, '0, 1'b0, "R10 restore bank0");
        wr_mask(1'b1, '0, 1'b0, "R10 restore bank1");
        for (int i = N - 1; i >= 0; i--) ack(i, "R6 drain");

        // acknowledge of a non-pending source changes nothing
        req[7] = 1'b1; req[20] = 1'b1; cyc("R1 two edges");
        req = '0;
        ack(3, "R6 ack idle src");
        ack(31, "R6 ack idle src high");
        ack(7, "R6 clear 7");
        ack(20, "R6 clear 20");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule